// File: doc/BRIEF.md
# Oversampled serial receiver with ninth-bit address filter

The block recovers asynchronous serial characters from one receive line. A free-running enable pulse at sixteen times the bit rate paces it. Each frame starts low, carries 8 or 9 data bits least significant first, may carry a parity bit (8-bit mode only), and ends with one or two high stop bits. Each recovered word is stored with its own error flags in a small first-in-first-out queue. A host drains the queue through a valid/ready stream.

The stream follows these rules. `out_valid` stays high while the queue holds a word. The head word and its flags stay stable until the host takes it by holding `out_ready` high on a clock edge. The block has no way to stall the remote sender other than `rts`, which drops when the queue is full. A word that completes while the queue is full and nothing is popped is dropped and counted as an overrun.

Two one-cycle pulses go to an interrupt controller. `rx_irq` marks each stored word. `err_irq` marks a stored word with a parity or framing error, or an overrun. In address mode, only 9-bit words with the top bit set enter the queue. A loopback select feeds a local transmit signal to the receiver in place of the pin.

Top module: `uart_addr_rx`

## Requirements
- R1: A falling line seen while idle starts a frame only if the line is still low 8 ticks later (the middle of the start bit). Otherwise it is ignored. Data bits are then sampled every 16 ticks, least significant bit first, 8 bits or 9 when `cfg_nine_bit`=1. In 8-bit mode `out_data[8]` reads 0.
- R2: Stored words leave in arrival order. The queue holds up to 4 words. `out_valid` is high exactly while it is non-empty. The head word stays stable while `out_ready` is low.
- R3: With `cfg_parity_en`=1 and `cfg_nine_bit`=0, one parity bit follows the data. It is even when `cfg_parity_odd`=0 and odd when it is 1. A mismatch sets `out_perr` on that word. In 9-bit mode no parity bit is expected.
- R4: A low first stop bit sets `out_ferr`. With `cfg_two_stop`=1 a second stop bit time follows before the next start can be seen. A break (all-zero frame with a low stop) is stored as data 0 with `out_ferr`=1. No further frame begins until the line has been seen high.
- R5: A word that completes while 4 words are held and none is popped in that cycle is discarded. The next word that is stored carries `out_oerr`=1, and later words carry 0.
- R6: `err_irq` pulses once for each stored word that has a parity or framing error, and once for each overrun. `rx_irq` pulses once for each stored word.
- R7: With `cfg_addr_mode`=1 in 9-bit mode, a word whose bit 8 is 0 is dropped without any pulse. A word whose bit 8 is 1 is stored.
- R8: `rts` is high while the queue has room. It is low while it holds 4 words, and high again the cycle after a word is read.
- R9: With `cfg_loopback`=1 the receiver listens to `tx_loop` and ignores `rx_pin`. With `cfg_loopback`=0 it listens to `rx_pin`.
- R10: After reset, `out_valid`, `rx_irq` and `err_irq` are 0 and `rts` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_pin | input | 1 | Receive line from the remote sender |
| tx_loop | input | 1 | Local transmit line, used in loopback |
| cfg_loopback | input | 1 | Select `tx_loop` as the receive source |
| cfg_nine_bit | input | 1 | 9 data bits instead of 8 |
| cfg_parity_en | input | 1 | Expect a parity bit (8-bit mode) |
| cfg_parity_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_addr_mode | input | 1 | Keep only 9-bit words with bit 8 set |
| out_valid | output | 1 | Queue head is valid |
| out_ready | input | 1 | Host takes the head word |
| out_data | output | 9 | Head word data |
| out_perr | output | 1 | Head word parity error |
| out_ferr | output | 1 | Head word framing error |
| out_oerr | output | 1 | Words were lost before the head word |
| rx_irq | output | 1 | Pulse per stored word |
| err_irq | output | 1 | Pulse per error or overrun |
| rts | output | 1 | Queue has room |

## Verification
The bench builds the block with its defaults:
- queue depth 4
- 16 ticks per bit
- two synchroniser stages

It feeds a tick every second clock, so one bit lasts 32 clocks.

With depth 4, five unread frames are enough to fill the queue, drop `rts` and force an overrun. The pending overrun flag can then be watched on the next stored word. The short bit time allows dozens of random-format frames, as well as the following directed cases, within the cycle budget:
- a glitch on the start bit
- a break
- address filtering
- loopback

// File: rtl/uart_addr_rx_pkg.sv
package uart_addr_rx_pkg;
  localparam int DATA_W = 9;

  typedef struct packed {
    logic              oerr;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_en,
  input  logic pin,
  input  logic loop_in,
  output logic line_o
);
  logic [STAGES-1:0] sr;
  logic raw;

  assign raw = loop_en ? loop_in : pin;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sr[0] <= 1'b1;
          else        sr[0] <= raw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sr[i] <= 1'b1;
          else        sr[i] <= sr[i-1];
      end
    end
  endgenerate

  assign line_o = sr[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_addr_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              nine_bit,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              two_stop,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int CW   = $clog2(OVS);
  localparam int MID  = OVS/2 - 1;
  localparam int LAST = OVS - 1;
  localparam int IW   = $clog2(DATA_W + 1);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              par_acc, armed, perr_q;
  logic [IW-1:0]     last_idx;
  logic              at_bit;

  assign last_idx = nine_bit ? IW'(DATA_W-1) : IW'(DATA_W-2);
  assign at_bit   = (cnt == CW'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; shreg <= '0;
      par_acc <= 1'b0; armed <= 1'b0; perr_q <= 1'b0;
      done <= 1'b0; data <= '0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        cnt <= cnt + 1'b1;
        case (st)
          S_IDLE: begin
            if (line) armed <= 1'b1;
            else if (armed) begin
              st <= S_START; cnt <= '0; armed <= 1'b0;
            end
          end
          S_START: if (cnt == CW'(MID)) begin
            cnt <= '0;
            if (!line) begin
              st <= S_DATA; idx <= '0; shreg <= '0; par_acc <= 1'b0; perr_q <= 1'b0;
            end else st <= S_IDLE;
          end
          S_DATA: if (at_bit) begin
            shreg[idx] <= line;
            par_acc    <= par_acc ^ line;
            idx        <= idx + 1'b1;
            if (idx == last_idx)
              st <= (parity_en && !nine_bit) ? S_PAR : S_STOP1;
          end
          S_PAR: if (at_bit) begin
            perr_q <= par_acc ^ line ^ parity_odd;
            st     <= S_STOP1;
          end
          S_STOP1: if (at_bit) begin
            data <= shreg; perr <= perr_q; ferr <= !line;
            if (two_stop && line) st <= S_STOP2;
            else begin
              st <= S_IDLE; done <= 1'b1;
            end
          end
          S_STOP2: if (at_bit) begin
            st <= S_IDLE; done <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_addr_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_word_t wdata,
  input  logic     pop,
  output rx_word_t rdata,
  output logic     empty,
  output logic     full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  rx_word_t      mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == NW'(DEPTH));
  assign rdata = mem[rptr];

  always_ff @(posedge clk) if (push) mem[wptr] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_addr_rx_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_pin,
  input  logic              tx_loop,
  input  logic              cfg_loopback,
  input  logic              cfg_nine_bit,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_addr_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr,
  output logic              out_oerr,
  output logic              rx_irq,
  output logic              err_irq,
  output logic              rts
);
  localparam int NW = $clog2(DEPTH + 1);

  logic              line;
  logic              frame_valid, frame_perr, frame_ferr;
  logic [DATA_W-1:0] frame_data;
  logic              addr_en, accept, pop, push, overrun, pend_ovf;
  logic              q_empty, q_full;
  logic [NW-1:0]     q_count;
  rx_word_t          head, wword;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .loop_en(cfg_loopback),
    .pin(rx_pin), .loop_in(tx_loop), .line_o(line));

  uart_rx_framer #(.OVS(OVS)) framer_i (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line),
    .nine_bit(cfg_nine_bit), .parity_en(cfg_parity_en),
    .parity_odd(cfg_parity_odd), .two_stop(cfg_two_stop),
    .done(frame_valid), .data(frame_data), .perr(frame_perr), .ferr(frame_ferr));

  assign addr_en = cfg_addr_mode && cfg_nine_bit;
  assign accept  = frame_valid && (!addr_en || frame_data[DATA_W-1]);
  assign pop     = out_valid && out_ready;
  assign overrun = accept && q_full && !pop;
  assign push    = accept && !overrun;

  assign wword.oerr = pend_ovf;
  assign wword.ferr = frame_ferr;
  assign wword.perr = frame_perr;
  assign wword.data = cfg_nine_bit ? frame_data : {1'b0, frame_data[DATA_W-2:0]};

  uart_rx_queue #(.DEPTH(DEPTH)) queue_i (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(wword), .pop(pop),
    .rdata(head), .empty(q_empty), .full(q_full), .count(q_count));

  assign out_valid = !q_empty;
  assign out_data  = head.data;
  assign out_perr  = head.perr;
  assign out_ferr  = head.ferr;
  assign out_oerr  = head.oerr;
  assign rts       = !q_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_ovf <= 1'b0; rx_irq <= 1'b0; err_irq <= 1'b0;
    end else begin
      if (overrun)   pend_ovf <= 1'b1;
      else if (push) pend_ovf <= 1'b0;
      rx_irq  <= push;
      err_irq <= overrun || (push && (frame_perr || frame_ferr));
    end
  end
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [8:0]                 out_data,
  input logic                       rts,
  input logic                       rx_irq,
  input logic                       err_irq,
  input logic                       push,
  input logic                       pop,
  input logic                       q_full,
  input logic [$clog2(DEPTH+1)-1:0] q_count,
  input logic                       frame_valid,
  input logic                       addr_en,
  input logic [8:0]                 frame_data
);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= ($clog2(DEPTH+1))'(DEPTH));

  a_r2_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !pop) |-> !push);

  a_r6_err_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> $past(frame_valid));

  a_r7_addr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && addr_en && !frame_data[8]) |=> !rx_irq);

  a_r8_rts_falls_on_push: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> $past(push));

  a_r8_rts_back_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts && pop && !push) |=> rts);
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .rts(rts), .rx_irq(rx_irq), .err_irq(err_irq),
  .push(push), .pop(pop), .q_full(q_full), .q_count(q_count),
  .frame_valid(frame_valid), .addr_en(addr_en), .frame_data(frame_data));

// File: tb/uart_addr_rx_tb_top.sv
module uart_addr_rx_tb_top;
  localparam int BIT_CLKS = 32;
  localparam int DEPTH    = 4;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rx_pin = 1'b1, tx_loop = 1'b1;
  logic cfg_loopback = 0, cfg_nine_bit = 0, cfg_parity_en = 0;
  logic cfg_parity_odd = 0, cfg_two_stop = 0, cfg_addr_mode = 0;
  logic out_valid, out_ready = 1'b0;
  logic [8:0] out_data;
  logic out_perr, out_ferr, out_oerr, rx_irq, err_irq, rts;

  int checks = 0, errs = 0;
  int rx_seen = 0, err_seen = 0, rx_exp = 0, err_exp = 0;
  int cyc = 0;
  bit pend_model = 0;
  bit done_flag = 0;
  logic [11:0] exp_q[$];

  always #2 clk = ~clk;

  uart_addr_rx dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_pin(rx_pin), .tx_loop(tx_loop),
    .cfg_loopback(cfg_loopback), .cfg_nine_bit(cfg_nine_bit),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_addr_mode(cfg_addr_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr), .out_ferr(out_ferr), .out_oerr(out_oerr),
    .rx_irq(rx_irq), .err_irq(err_irq), .rts(rts));

  always @(negedge clk) tick16 <= ~tick16;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && rx_irq)  rx_seen  <= rx_seen + 1;
    if (rst_n && err_irq) err_seen <= err_seen + 1;
    if (cyc == WATCHDOG && !done_flag) begin
      done_flag = 1;
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic v, input bit lp);
    if (lp) tx_loop = v; else rx_pin = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  function automatic logic par_of(input logic [8:0] d, input bit odd);
    return (^d[7:0]) ^ odd;
  endfunction

  // Drive one frame using the current config, then 2 idle bits.
  task automatic send(input logic [8:0] d, input bit badpar, input bit badstop, input bit lp);
    int nb;
    nb = cfg_nine_bit ? 9 : 8;
    put(1'b0, lp);
    for (int i = 0; i < nb; i++) put(d[i], lp);
    if (cfg_parity_en && !cfg_nine_bit) put(par_of(d, cfg_parity_odd) ^ badpar, lp);
    put(!badstop, lp);
    if (cfg_two_stop) put(1'b1, lp);
    put(1'b1, lp); put(1'b1, lp);
  endtask

  // Reference model of what one sent frame does to the queue.
  task automatic model(input logic [8:0] d, input bit badpar, input bit badstop);
    logic [8:0] dd;
    bit pe, fe;
    dd = cfg_nine_bit ? d : {1'b0, d[7:0]};
    pe = cfg_parity_en && !cfg_nine_bit && badpar;
    fe = badstop;
    if (cfg_addr_mode && cfg_nine_bit && !d[8]) return;
    if (exp_q.size() == DEPTH) begin
      pend_model = 1; err_exp++;
    end else begin
      exp_q.push_back({pend_model, fe, pe, dd});
      pend_model = 0; rx_exp++;
      if (pe || fe) err_exp++;
    end
  endtask

  task automatic read_one(input string req);
    logic [11:0] e;
    int t;
    t = 0;
    while (!out_valid && t < 4000) begin @(negedge clk); t++; end
    e = exp_q.pop_front();
    check(out_valid, req, out_valid, 1);
    check({out_oerr, out_ferr, out_perr, out_data} == e, req,
          {out_oerr, out_ferr, out_perr, out_data}, e);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic drain(input string req);
    while (exp_q.size() != 0) read_one(req);
    check(!out_valid, {req, " empty"}, out_valid, 0);
    check(rx_seen == rx_exp, "R6 rx_irq", rx_seen, rx_exp);
    check(err_seen == err_exp, "R6 err_irq", err_seen, err_exp);
  endtask

  task automatic xfer(input logic [8:0] d, input bit bp, input bit bs, input string req);
    send(d, bp, bs, cfg_loopback);
    model(d, bp, bs);
    drain(req);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    check(!out_valid && !rx_irq && !err_irq && rts, "R10 reset",
          {out_valid, rx_irq, err_irq, rts}, 4'b0001);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);

    // R1 basic 8-bit, LSB first
    xfer(9'h0a5, 0, 0, "R1 8bit");
    xfer(9'h13c, 0, 0, "R1 8bit top bit masked");
    // R1 glitch on start bit: 4 ticks low
    rx_pin = 1'b0; repeat (8) @(negedge clk); rx_pin = 1'b1;
    repeat (BIT_CLKS * 12) @(negedge clk);
    check(!out_valid && rx_seen == rx_exp, "R1 glitch rejected", out_valid, 0);
    // R1 9-bit
    cfg_nine_bit = 1;
    xfer(9'h1c3, 0, 0, "R1 9bit");
    // R3 parity: 9-bit ignores parity enable
    cfg_parity_en = 1;
    xfer(9'h055, 0, 0, "R3 no parity in 9bit");
    cfg_nine_bit = 0;
    cfg_parity_odd = 0;
    xfer(9'h0b7, 0, 0, "R3 even ok");
    xfer(9'h0b7, 1, 0, "R3 even bad");
    cfg_parity_odd = 1;
    xfer(9'h031, 0, 0, "R3 odd ok");
    xfer(9'h031, 1, 0, "R3 odd bad");
    cfg_parity_en = 0; cfg_parity_odd = 0;
    // R4 framing, two stop, break
    xfer(9'h0e1, 0, 1, "R4 framing");
    cfg_two_stop = 1;
    xfer(9'h07e, 0, 0, "R4 two stop");
    cfg_two_stop = 0;
    xfer(9'h000, 0, 1, "R4 break");
    // R7 address filter
    cfg_nine_bit = 1; cfg_addr_mode = 1;
    xfer(9'h0aa, 0, 0, "R7 drop addr0");
    xfer(9'h155, 0, 0, "R7 keep addr1");
    cfg_addr_mode = 0; cfg_nine_bit = 0;
    // R8/R5 fill queue then overrun
    for (int i = 0; i < DEPTH; i++) begin
      send(9'(8'h10 + i), 0, 0, 0); model(9'(8'h10 + i), 0, 0);
    end
    check(!rts, "R8 rts low when full", rts, 0);
    send(9'h0ee, 0, 0, 0); model(9'h0ee, 0, 0);
    check(err_seen == err_exp, "R5 overrun err_irq", err_seen, err_exp);
    read_one("R2 order");
    check(rts, "R8 rts back after read", rts, 1);
    drain("R2 order");
    xfer(9'h042, 0, 0, "R5 oerr on next word");
    xfer(9'h043, 0, 0, "R5 oerr cleared");
    // R9 loopback
    cfg_loopback = 1;
    xfer(9'h0c9, 0, 0, "R9 loopback");
    send(9'h011, 0, 0, 0);
    check(!out_valid && rx_seen == rx_exp, "R9 pin ignored", out_valid, 0);
    cfg_loopback = 0;
    send(9'h011, 0, 0, 1);
    check(!out_valid && rx_seen == rx_exp, "R9 loop input ignored", out_valid, 0);
    // Random frames
    for (int n = 0; n < 40; n++) begin
      logic [8:0] d;
      d = 9'($urandom);
      cfg_nine_bit   = $urandom_range(0, 1);
      cfg_parity_en  = $urandom_range(0, 1);
      cfg_parity_odd = $urandom_range(0, 1);
      cfg_two_stop   = $urandom_range(0, 1);
      cfg_addr_mode  = ($urandom_range(0, 3) == 0);
      xfer(d, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0, "R1 random");
    end
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule